// File: doc/BRIEF.md
# Instruction Decode and Execute Stage

This block turns one 32-bit instruction word and the two register values read for it into a finished result for the writeback stage. It is purely combinational. It splits the word into its fields and decides from the primary opcode, and for register-register forms from the function field, which operation to run. It forms the second operand from either the second register or an extended immediate, and it evaluates the operation in a single ALU. It also reports which register, if any, should be written.

Loads and stores pass through the same path. The block adds the base register to the sign-extended 16-bit offset and raises a load or store flag, so that a memory stage placed after it can use the address. The register file, the memory, program-counter sequencing, multiply/divide and overflow traps sit outside this block. Branches, jumps and any encoding the block does not recognise pass through with no side effect.

Top module: `decx_unit`

## Requirements
- R1: A source operand whose register index field (rs at bits 25:21, rt at bits 20:16) is 0 is taken as zero, whatever value is presented on the matching value input.
- R2: With opcode 0x00, function 0x21 gives rs+rt and function 0x23 gives rs-rt, both modulo 2^32 and with no overflow detection.
- R3: With opcode 0x00, function 0x25 gives rs OR rt, 0x26 gives rs XOR rt, and 0x27 gives the inverse of (rs OR rt).
- R4: With opcode 0x00, function 0x00 shifts rt left, 0x02 shifts rt right filling with zeros, and 0x03 shifts rt right copying the sign bit. The amount is the shift field at bits 10:6, and an amount of 0 returns rt unchanged.
- R5: Opcode 0x09 adds rs to the 16-bit immediate at bits 15:0, extended by copying its bit 15.
- R6: Opcode 0x0c gives rs AND the immediate, and opcode 0x0d gives rs OR the immediate. Both extend the immediate with zeros.
- R7: Opcode 0x0f returns the immediate in bits 31:16 with bits 15:0 zero. The rs value has no effect.
- R8: Opcode 0x0a returns 1 when rs, read as a signed number, is below the sign-extended immediate, and returns 0 otherwise.
- R9: Load opcodes (0x20, 0x21, 0x23, 0x24, 0x25) raise the load flag, and store opcodes (0x28, 0x29, 0x2b) raise the store flag and never the write enable. For both, the address output and the result carry rs plus the sign-extended immediate.
- R10: Register-register operations name the destination with the rd field (bits 15:11). Immediate operations and loads name it with the rt field. The write enable stays low when the destination index is 0.
- R11: Branches (opcodes 0x01, 0x04, 0x05, 0x06, 0x07), jumps (0x02, 0x03), opcode 0x00 with any other function code, and all other opcodes drive write enable, load flag and store flag low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| insn_i | input | 32 | Instruction word |
| rs_val_i | input | 32 | Value read for the rs index |
| rt_val_i | input | 32 | Value read for the rt index |
| result_o | output | 32 | Operation result (the address for loads and stores) |
| wr_idx_o | output | 5 | Destination register index |
| wr_en_o | output | 1 | Destination register write enable |
| mem_addr_o | output | 32 | Base plus sign-extended offset |
| mem_load_o | output | 1 | Instruction is a load |
| mem_store_o | output | 1 | Instruction is a store |

## Verification
Nothing in the block holds state, so a decode fault shows at the ports as soon as the faulty instruction is presented. Such a fault could be a wrong extension kind, a wrong destination selector, or a missing register-0 override. It would appear as a wrong result, a wrong destination index, or a write enable on an instruction that must write nothing. The vectors therefore pair each opcode with operand values whose upper bits tell sign extension from zero extension, and whose sign bits tell signed comparison from unsigned comparison. Every write-free class, stores and a zero destination among them, is checked directly on the enable and flag outputs.

// File: rtl/decx_pkg.sv
package decx_pkg;

    // Datapath and field geometry
    localparam int XLEN      = 32;
    localparam int REG_IDX_W = 5;
    localparam int IMM_W     = 16;
    localparam int SHAMT_W   = 5;
    localparam int OPC_W     = 6;
    localparam int FUNCT_W   = 6;

    localparam int FUNCT_LSB = 0;
    localparam int SHAMT_LSB = FUNCT_LSB + FUNCT_W;
    localparam int RD_LSB    = SHAMT_LSB + SHAMT_W;
    localparam int RT_LSB    = RD_LSB + REG_IDX_W;
    localparam int RS_LSB    = RT_LSB + REG_IDX_W;
    localparam int OPC_LSB   = RS_LSB + REG_IDX_W;
    localparam int INSN_W    = OPC_LSB + OPC_W;
    localparam int IMM_LSB   = 0;

    // Primary opcodes
    localparam logic [OPC_W-1:0] OPC_REGREG = 6'h00;
    localparam logic [OPC_W-1:0] OPC_ADDIU  = 6'h09;
    localparam logic [OPC_W-1:0] OPC_SLTI   = 6'h0a;
    localparam logic [OPC_W-1:0] OPC_ANDI   = 6'h0c;
    localparam logic [OPC_W-1:0] OPC_ORI    = 6'h0d;
    localparam logic [OPC_W-1:0] OPC_LUI    = 6'h0f;
    localparam logic [OPC_W-1:0] OPC_LB     = 6'h20;
    localparam logic [OPC_W-1:0] OPC_LH     = 6'h21;
    localparam logic [OPC_W-1:0] OPC_LW     = 6'h23;
    localparam logic [OPC_W-1:0] OPC_LBU    = 6'h24;
    localparam logic [OPC_W-1:0] OPC_LHU    = 6'h25;
    localparam logic [OPC_W-1:0] OPC_SB     = 6'h28;
    localparam logic [OPC_W-1:0] OPC_SH     = 6'h29;
    localparam logic [OPC_W-1:0] OPC_SW     = 6'h2b;

    // Function codes under OPC_REGREG
    localparam logic [FUNCT_W-1:0] FN_SLL  = 6'h00;
    localparam logic [FUNCT_W-1:0] FN_SRL  = 6'h02;
    localparam logic [FUNCT_W-1:0] FN_SRA  = 6'h03;
    localparam logic [FUNCT_W-1:0] FN_ADDU = 6'h21;
    localparam logic [FUNCT_W-1:0] FN_SUBU = 6'h23;
    localparam logic [FUNCT_W-1:0] FN_OR   = 6'h25;
    localparam logic [FUNCT_W-1:0] FN_XOR  = 6'h26;
    localparam logic [FUNCT_W-1:0] FN_NOR  = 6'h27;

    typedef enum logic [3:0] {
        ALU_ADD, ALU_SUB, ALU_AND, ALU_OR, ALU_XOR, ALU_NOR,
        ALU_SLL, ALU_SRL, ALU_SRA, ALU_SLT, ALU_PASSB, ALU_NONE
    } alu_op_e;

    typedef enum logic [1:0] {
        IMM_SIGN, IMM_ZERO, IMM_UPPER
    } imm_kind_e;

    typedef enum logic { BSRC_REG, BSRC_IMM } bsrc_e;
    typedef enum logic { DEST_RD, DEST_RT } dest_e;

    typedef struct packed {
        logic [OPC_W-1:0]     opc;
        logic [REG_IDX_W-1:0] rs;
        logic [REG_IDX_W-1:0] rt;
        logic [REG_IDX_W-1:0] rd;
        logic [SHAMT_W-1:0]   shamt;
        logic [FUNCT_W-1:0]   funct;
        logic [IMM_W-1:0]     imm;
    } insn_fields_t;

    typedef struct packed {
        alu_op_e   alu_op;
        imm_kind_e imm_kind;
        bsrc_e     b_src;
        dest_e     dest;
        logic      reg_write;
        logic      mem_load;
        logic      mem_store;
    } dec_ctrl_t;

    function automatic logic [XLEN-1:0] extend_imm(input logic [IMM_W-1:0] imm,
                                                   input imm_kind_e kind);
        logic [XLEN-1:0] zx;
        zx = {{(XLEN-IMM_W){1'b0}}, imm};
        case (kind)
            IMM_SIGN:  extend_imm = {{(XLEN-IMM_W){imm[IMM_W-1]}}, imm};
            IMM_ZERO:  extend_imm = zx;
            IMM_UPPER: extend_imm = zx << IMM_W;
            default:   extend_imm = '0;
        endcase
    endfunction

    function automatic logic [XLEN-1:0] gate_zero_reg(input logic [REG_IDX_W-1:0] idx,
                                                      input logic [XLEN-1:0] val);
        gate_zero_reg = (idx == '0) ? '0 : val;
    endfunction

endpackage

// File: rtl/decx_fields.sv
module decx_fields
    import decx_pkg::*;
(
    input  logic [INSN_W-1:0] insn_i,
    output insn_fields_t      fields_o
);
    always_comb begin
        fields_o.opc   = insn_i[OPC_LSB   +: OPC_W];
        fields_o.rs    = insn_i[RS_LSB    +: REG_IDX_W];
        fields_o.rt    = insn_i[RT_LSB    +: REG_IDX_W];
        fields_o.rd    = insn_i[RD_LSB    +: REG_IDX_W];
        fields_o.shamt = insn_i[SHAMT_LSB +: SHAMT_W];
        fields_o.funct = insn_i[FUNCT_LSB +: FUNCT_W];
        fields_o.imm   = insn_i[IMM_LSB   +: IMM_W];
    end
endmodule

// File: rtl/decx_ctrl.sv
module decx_ctrl
    import decx_pkg::*;
(
    input  logic [OPC_W-1:0]   opc_i,
    input  logic [FUNCT_W-1:0] funct_i,
    output dec_ctrl_t          ctrl_o
);
    always_comb begin
        ctrl_o.alu_op    = ALU_NONE;
        ctrl_o.imm_kind  = IMM_SIGN;
        ctrl_o.b_src     = BSRC_REG;
        ctrl_o.dest      = DEST_RT;
        ctrl_o.reg_write = 1'b0;
        ctrl_o.mem_load  = 1'b0;
        ctrl_o.mem_store = 1'b0;

        case (opc_i)
            OPC_REGREG: begin
                ctrl_o.dest = DEST_RD;
                case (funct_i)
                    FN_ADDU: begin ctrl_o.alu_op = ALU_ADD; ctrl_o.reg_write = 1'b1; end
                    FN_SUBU: begin ctrl_o.alu_op = ALU_SUB; ctrl_o.reg_write = 1'b1; end
                    FN_OR:   begin ctrl_o.alu_op = ALU_OR;  ctrl_o.reg_write = 1'b1; end
                    FN_XOR:  begin ctrl_o.alu_op = ALU_XOR; ctrl_o.reg_write = 1'b1; end
                    FN_NOR:  begin ctrl_o.alu_op = ALU_NOR; ctrl_o.reg_write = 1'b1; end
                    FN_SLL:  begin ctrl_o.alu_op = ALU_SLL; ctrl_o.reg_write = 1'b1; end
                    FN_SRL:  begin ctrl_o.alu_op = ALU_SRL; ctrl_o.reg_write = 1'b1; end
                    FN_SRA:  begin ctrl_o.alu_op = ALU_SRA; ctrl_o.reg_write = 1'b1; end
                    default: ;
                endcase
            end
            OPC_ADDIU: begin
                ctrl_o.alu_op = ALU_ADD; ctrl_o.b_src = BSRC_IMM;
                ctrl_o.imm_kind = IMM_SIGN; ctrl_o.reg_write = 1'b1;
            end
            OPC_SLTI: begin
                ctrl_o.alu_op = ALU_SLT; ctrl_o.b_src = BSRC_IMM;
                ctrl_o.imm_kind = IMM_SIGN; ctrl_o.reg_write = 1'b1;
            end
            OPC_ANDI: begin
                ctrl_o.alu_op = ALU_AND; ctrl_o.b_src = BSRC_IMM;
                ctrl_o.imm_kind = IMM_ZERO; ctrl_o.reg_write = 1'b1;
            end
            OPC_ORI: begin
                ctrl_o.alu_op = ALU_OR; ctrl_o.b_src = BSRC_IMM;
                ctrl_o.imm_kind = IMM_ZERO; ctrl_o.reg_write = 1'b1;
            end
            OPC_LUI: begin
                ctrl_o.alu_op = ALU_PASSB; ctrl_o.b_src = BSRC_IMM;
                ctrl_o.imm_kind = IMM_UPPER; ctrl_o.reg_write = 1'b1;
            end
            OPC_LB, OPC_LH, OPC_LW, OPC_LBU, OPC_LHU: begin
                ctrl_o.alu_op = ALU_ADD; ctrl_o.b_src = BSRC_IMM;
                ctrl_o.imm_kind = IMM_SIGN; ctrl_o.reg_write = 1'b1;
                ctrl_o.mem_load = 1'b1;
            end
            OPC_SB, OPC_SH, OPC_SW: begin
                ctrl_o.alu_op = ALU_ADD; ctrl_o.b_src = BSRC_IMM;
                ctrl_o.imm_kind = IMM_SIGN; ctrl_o.mem_store = 1'b1;
            end
            default: ;
        endcase
    end

    always_comb begin
        AST_MEM_FLAGS_EXCLUSIVE: assert (!(ctrl_o.mem_load && ctrl_o.mem_store))
            else $error("AST_MEM_FLAGS_EXCLUSIVE"); // R9
    end

    always_comb begin
        AST_STORE_NO_REGWRITE: assert (!(ctrl_o.mem_store && ctrl_o.reg_write))
            else $error("AST_STORE_NO_REGWRITE"); // R9
    end
endmodule

// File: rtl/decx_operands.sv
module decx_operands
    import decx_pkg::*;
(
    input  logic [REG_IDX_W-1:0] rs_idx_i,
    input  logic [REG_IDX_W-1:0] rt_idx_i,
    input  logic [XLEN-1:0]      rs_val_i,
    input  logic [XLEN-1:0]      rt_val_i,
    input  logic [IMM_W-1:0]     imm_i,
    input  imm_kind_e            imm_kind_i,
    input  bsrc_e                b_src_i,
    output logic [XLEN-1:0]      a_op_o,
    output logic [XLEN-1:0]      b_op_o,
    output logic [XLEN-1:0]      offset_o
);
    logic [XLEN-1:0] rt_eff;
    logic [XLEN-1:0] imm_ext;

    always_comb begin
        a_op_o   = gate_zero_reg(rs_idx_i, rs_val_i);
        rt_eff   = gate_zero_reg(rt_idx_i, rt_val_i);
        imm_ext  = extend_imm(imm_i, imm_kind_i);
        offset_o = extend_imm(imm_i, IMM_SIGN);
        b_op_o   = (b_src_i == BSRC_IMM) ? imm_ext : rt_eff;
    end
endmodule

// File: rtl/decx_alu.sv
module decx_alu
    import decx_pkg::*;
(
    input  alu_op_e            op_i,
    input  logic [XLEN-1:0]    a_i,
    input  logic [XLEN-1:0]    b_i,
    input  logic [SHAMT_W-1:0] shamt_i,
    output logic [XLEN-1:0]    y_o
);
    always_comb begin
        case (op_i)
            ALU_ADD:   y_o = a_i + b_i;
            ALU_SUB:   y_o = a_i - b_i;
            ALU_AND:   y_o = a_i & b_i;
            ALU_OR:    y_o = a_i | b_i;
            ALU_XOR:   y_o = a_i ^ b_i;
            ALU_NOR:   y_o = ~(a_i | b_i);
            ALU_SLL:   y_o = b_i << shamt_i;
            ALU_SRL:   y_o = b_i >> shamt_i;
            ALU_SRA:   y_o = $unsigned($signed(b_i) >>> shamt_i);
            ALU_SLT:   y_o = {{(XLEN-1){1'b0}}, ($signed(a_i) < $signed(b_i))};
            ALU_PASSB: y_o = b_i;
            default:   y_o = '0;
        endcase
    end

    always_comb begin
        AST_SLT_IS_BOOLEAN: assert (op_i != ALU_SLT || y_o[XLEN-1:1] == '0)
            else $error("AST_SLT_IS_BOOLEAN"); // R8
    end

    always_comb begin
        AST_UPPER_LOW_CLEAR: assert (op_i != ALU_PASSB || y_o[IMM_W-1:0] == '0)
            else $error("AST_UPPER_LOW_CLEAR"); // R7
    end
endmodule

// File: rtl/decx_unit.sv
module decx_unit
    import decx_pkg::*;
(
    input  logic [31:0] insn_i,
    input  logic [31:0] rs_val_i,
    input  logic [31:0] rt_val_i,
    output logic [31:0] result_o,
    output logic [4:0]  wr_idx_o,
    output logic        wr_en_o,
    output logic [31:0] mem_addr_o,
    output logic        mem_load_o,
    output logic        mem_store_o
);
    insn_fields_t    fld;
    dec_ctrl_t       ctl;
    logic [XLEN-1:0] a_op;
    logic [XLEN-1:0] b_op;
    logic [XLEN-1:0] offset;
    logic [XLEN-1:0] alu_y;
    logic [XLEN-1:0] addr_sum;
    logic [REG_IDX_W-1:0] dest_idx;

    decx_fields u_fields (
        .insn_i   (insn_i),
        .fields_o (fld)
    );

    decx_ctrl u_ctrl (
        .opc_i   (fld.opc),
        .funct_i (fld.funct),
        .ctrl_o  (ctl)
    );

    decx_operands u_operands (
        .rs_idx_i   (fld.rs),
        .rt_idx_i   (fld.rt),
        .rs_val_i   (rs_val_i),
        .rt_val_i   (rt_val_i),
        .imm_i      (fld.imm),
        .imm_kind_i (ctl.imm_kind),
        .b_src_i    (ctl.b_src),
        .a_op_o     (a_op),
        .b_op_o     (b_op),
        .offset_o   (offset)
    );

    decx_alu u_alu (
        .op_i    (ctl.alu_op),
        .a_i     (a_op),
        .b_i     (b_op),
        .shamt_i (fld.shamt),
        .y_o     (alu_y)
    );

    // Dedicated address adder: the address is ready without the ALU mux
    always_comb begin
        addr_sum = a_op + offset;
        dest_idx = (ctl.dest == DEST_RD) ? fld.rd : fld.rt;
    end

    assign result_o    = alu_y;
    assign wr_idx_o    = dest_idx;
    assign wr_en_o     = ctl.reg_write && (dest_idx != '0);
    assign mem_addr_o  = addr_sum;
    assign mem_load_o  = ctl.mem_load;
    assign mem_store_o = ctl.mem_store;

    always_comb begin
        AST_ADDR_MATCHES_ALU: assert (!(ctl.mem_load || ctl.mem_store) || alu_y == addr_sum)
            else $error("AST_ADDR_MATCHES_ALU"); // R9
    end

    always_comb begin
        AST_ZERO_BASE_ADDR: assert (!((ctl.mem_load || ctl.mem_store) && fld.rs == '0)
                                    || mem_addr_o == {{(XLEN-IMM_W){fld.imm[IMM_W-1]}}, fld.imm})
            else $error("AST_ZERO_BASE_ADDR"); // R1
    end
endmodule

// File: tb/decx_unit_tb.sv
module decx_unit_tb_top;

    typedef struct packed {
        logic [31:0] insn;
        logic [31:0] a;
        logic [31:0] b;
        logic [31:0] res;
        logic [4:0]  idx;
        logic        we;
        logic        ld;
        logic        st;
        logic [31:0] addr;
        logic [7:0]  req;
    } vec_t;

    function automatic logic [31:0] enc_r(input int rs, input int rt, input int rd,
                                          input int sh, input int fn);
        logic [4:0] s5, t5, d5, h5;
        logic [5:0] f6;
        s5 = rs[4:0]; t5 = rt[4:0]; d5 = rd[4:0]; h5 = sh[4:0]; f6 = fn[5:0];
        enc_r = {6'h00, s5, t5, d5, h5, f6};
    endfunction

    function automatic logic [31:0] enc_i(input int op, input int rs, input int rt,
                                          input int imm);
        logic [5:0] o6;
        logic [4:0] s5, t5;
        logic [15:0] i16;
        o6 = op[5:0]; s5 = rs[4:0]; t5 = rt[4:0]; i16 = imm[15:0];
        enc_i = {o6, s5, t5, i16};
    endfunction

    localparam int NV = 45;
    // fields: insn, rs value, rt value, result, dest, we, load, store, address, requirement
    localparam vec_t VECS [NV] = '{
        // R2 add/sub
        '{enc_r(1,2,3,0,'h21), 32'h5, 32'h7, 32'hC, 5'd3, 1'b1, 1'b0, 1'b0, 32'h0, 8'd2},
        '{enc_r(1,2,4,0,'h21), 32'hFFFFFFFF, 32'h2, 32'h1, 5'd4, 1'b1, 1'b0, 1'b0, 32'h0, 8'd2},
        '{enc_r(1,2,5,0,'h23), 32'h3, 32'h5, 32'hFFFFFFFE, 5'd5, 1'b1, 1'b0, 1'b0, 32'h0, 8'd2},
        // R3 logic
        '{enc_r(1,2,6,0,'h25), 32'hF0F00000, 32'h00000F0F, 32'hF0F00F0F, 5'd6, 1'b1, 1'b0, 1'b0, 32'h0, 8'd3},
        '{enc_r(1,2,7,0,'h26), 32'hFF00FF00, 32'h0FF00FF0, 32'hF0F0F0F0, 5'd7, 1'b1, 1'b0, 1'b0, 32'h0, 8'd3},
        '{enc_r(1,2,8,0,'h27), 32'h0000FFFF, 32'h00FF0000, 32'hFF000000, 5'd8, 1'b1, 1'b0, 1'b0, 32'h0, 8'd3},
        // R4 shifts
        '{enc_r(0,2,9,4,'h00), 32'hDEADBEEF, 32'h12345678, 32'h23456780, 5'd9, 1'b1, 1'b0, 1'b0, 32'h0, 8'd4},
        '{enc_r(3,2,10,8,'h02), 32'h1, 32'h80000000, 32'h00800000, 5'd10, 1'b1, 1'b0, 1'b0, 32'h0, 8'd4},
        '{enc_r(3,2,11,8,'h03), 32'h1, 32'h80000000, 32'hFF800000, 5'd11, 1'b1, 1'b0, 1'b0, 32'h0, 8'd4},
        '{enc_r(3,2,12,31,'h03), 32'h1, 32'h7FFFFFFF, 32'h0, 5'd12, 1'b1, 1'b0, 1'b0, 32'h0, 8'd4},
        '{enc_r(3,2,12,0,'h00), 32'h1, 32'hABCD0123, 32'hABCD0123, 5'd12, 1'b1, 1'b0, 1'b0, 32'h0, 8'd4},
        // R5 add immediate
        '{enc_i('h09,1,13,'hFFFF), 32'd10, 32'h0, 32'd9, 5'd13, 1'b1, 1'b0, 1'b0, 32'h0, 8'd5},
        '{enc_i('h09,1,13,'h7FFF), 32'h1, 32'hFFFFFFFF, 32'h8000, 5'd13, 1'b1, 1'b0, 1'b0, 32'h0, 8'd5},
        // R6 logic immediate
        '{enc_i('h0c,1,14,'h8001), 32'hFFFFFFFF, 32'h0, 32'h00008001, 5'd14, 1'b1, 1'b0, 1'b0, 32'h0, 8'd6},
        '{enc_i('h0d,1,15,'h8000), 32'h12340000, 32'h0, 32'h12348000, 5'd15, 1'b1, 1'b0, 1'b0, 32'h0, 8'd6},
        // R7 upper immediate
        '{enc_i('h0f,0,16,'hBEEF), 32'h0, 32'h0, 32'hBEEF0000, 5'd16, 1'b1, 1'b0, 1'b0, 32'h0, 8'd7},
        '{enc_i('h0f,7,16,'h0001), 32'hFFFFFFFF, 32'hFFFFFFFF, 32'h00010000, 5'd16, 1'b1, 1'b0, 1'b0, 32'h0, 8'd7},
        // R8 set-less-than immediate
        '{enc_i('h0a,1,17,'hFFFF), 32'hFFFFFFFE, 32'h0, 32'h1, 5'd17, 1'b1, 1'b0, 1'b0, 32'h0, 8'd8},
        '{enc_i('h0a,1,17,'h0005), 32'h5, 32'h0, 32'h0, 5'd17, 1'b1, 1'b0, 1'b0, 32'h0, 8'd8},
        '{enc_i('h0a,1,17,'h0000), 32'h80000000, 32'h0, 32'h1, 5'd17, 1'b1, 1'b0, 1'b0, 32'h0, 8'd8},
        '{enc_i('h0a,1,17,'hFFFF), 32'h0, 32'h0, 32'h0, 5'd17, 1'b1, 1'b0, 1'b0, 32'h0, 8'd8},
        // R9 loads and stores
        '{enc_i('h23,1,18,'h0014), 32'h1000, 32'h0, 32'h1014, 5'd18, 1'b1, 1'b1, 1'b0, 32'h1014, 8'd9},
        '{enc_i('h20,1,19,'hFFFC), 32'h1000, 32'h0, 32'h0FFC, 5'd19, 1'b1, 1'b1, 1'b0, 32'h0FFC, 8'd9},
        '{enc_i('h24,2,19,'h0002), 32'h0, 32'h0, 32'h2, 5'd19, 1'b1, 1'b1, 1'b0, 32'h2, 8'd9},
        '{enc_i('h21,1,19,'h0010), 32'hFFFFFFF0, 32'h0, 32'h0, 5'd19, 1'b1, 1'b1, 1'b0, 32'h0, 8'd9},
        '{enc_i('h25,1,19,'h0001), 32'h7FFFFFFF, 32'h0, 32'h80000000, 5'd19, 1'b1, 1'b1, 1'b0, 32'h80000000, 8'd9},
        '{enc_i('h2b,1,20,'h0008), 32'h2000, 32'h55, 32'h2008, 5'd20, 1'b0, 1'b0, 1'b1, 32'h2008, 8'd9},
        '{enc_i('h28,1,20,'hFFFF), 32'h10, 32'h55, 32'hF, 5'd20, 1'b0, 1'b0, 1'b1, 32'hF, 8'd9},
        '{enc_i('h29,1,20,'h0002), 32'hFFFFFFFE, 32'h1, 32'h0, 5'd20, 1'b0, 1'b0, 1'b1, 32'h0, 8'd9},
        // R11 write-free encodings
        '{enc_i('h04,1,2,'h0003), 32'h5, 32'h5, 32'h0, 5'd0, 1'b0, 1'b0, 1'b0, 32'h0, 8'd11},
        '{enc_i('h05,1,2,'h0003), 32'h5, 32'h6, 32'h0, 5'd0, 1'b0, 1'b0, 1'b0, 32'h0, 8'd11},
        '{enc_i('h01,1,1,'h0002), 32'h5, 32'h6, 32'h0, 5'd0, 1'b0, 1'b0, 1'b0, 32'h0, 8'd11},
        '{enc_i('h07,1,0,'h0010), 32'h5, 32'h6, 32'h0, 5'd0, 1'b0, 1'b0, 1'b0, 32'h0, 8'd11},
        '{{6'h02, 26'h0100000}, 32'h5, 32'h6, 32'h0, 5'd0, 1'b0, 1'b0, 1'b0, 32'h0, 8'd11},
        '{enc_r(1,2,3,0,'h20), 32'h5, 32'h6, 32'h0, 5'd0, 1'b0, 1'b0, 1'b0, 32'h0, 8'd11},
        '{enc_r(3,0,0,0,'h08), 32'h5, 32'h6, 32'h0, 5'd0, 1'b0, 1'b0, 1'b0, 32'h0, 8'd11},
        '{enc_i('h3f,1,2,'h1234), 32'h5, 32'h6, 32'h0, 5'd0, 1'b0, 1'b0, 1'b0, 32'h0, 8'd11},
        // R10 destination 0 writes nothing
        '{enc_r(1,2,0,0,'h21), 32'h5, 32'h6, 32'h0, 5'd0, 1'b0, 1'b0, 1'b0, 32'h0, 8'd10},
        '{enc_i('h09,1,0,'h0001), 32'h5, 32'h6, 32'h0, 5'd0, 1'b0, 1'b0, 1'b0, 32'h0, 8'd10},
        '{enc_i('h23,1,0,'h0004), 32'h100, 32'h0, 32'h104, 5'd0, 1'b0, 1'b1, 1'b0, 32'h104, 8'd10},
        // R1 register 0 reads as zero
        '{enc_r(0,2,21,0,'h21), 32'h5555, 32'h1, 32'h1, 5'd21, 1'b1, 1'b0, 1'b0, 32'h0, 8'd1},
        '{enc_r(1,0,22,0,'h23), 32'h9, 32'h77, 32'h9, 5'd22, 1'b1, 1'b0, 1'b0, 32'h0, 8'd1},
        '{enc_r(1,0,23,3,'h00), 32'h9, 32'hFF, 32'h0, 5'd23, 1'b1, 1'b0, 1'b0, 32'h0, 8'd1},
        '{enc_i('h2b,0,5,'h0040), 32'hABCD, 32'h3, 32'h40, 5'd5, 1'b0, 1'b0, 1'b1, 32'h40, 8'd1},
        '{enc_i('h09,0,24,'h8000), 32'h1234, 32'h0, 32'hFFFF8000, 5'd24, 1'b1, 1'b0, 1'b0, 32'h0, 8'd1}
    };

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic [31:0] insn;
    logic [31:0] rs_val;
    logic [31:0] rt_val;
    logic [31:0] result;
    logic [4:0]  wr_idx;
    logic        wr_en;
    logic [31:0] mem_addr;
    logic        mem_load;
    logic        mem_store;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    decx_unit dut_i (
        .insn_i      (insn),
        .rs_val_i    (rs_val),
        .rt_val_i    (rt_val),
        .result_o    (result),
        .wr_idx_o    (wr_idx),
        .wr_en_o     (wr_en),
        .mem_addr_o  (mem_addr),
        .mem_load_o  (mem_load),
        .mem_store_o (mem_store)
    );

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic apply(input logic [31:0] i, input logic [31:0] a, input logic [31:0] b);
        @(posedge clk);
        insn = i; rs_val = a; rt_val = b;
        @(negedge clk);
    endtask

    initial begin
        insn = '0; rs_val = '0; rt_val = '0;
        repeat (3) @(posedge clk);
        rst = 1'b0;
        @(negedge clk);
        // Idle word during reset: shift into register 0, nothing written (R10, R11)
        chk("R10", "idle wr_en", {31'b0, wr_en}, 32'h0);
        chk("R11", "idle load", {31'b0, mem_load}, 32'h0);
        chk("R11", "idle store", {31'b0, mem_store}, 32'h0);

        for (int k = 0; k < NV; k++) begin
            string tag;
            apply(VECS[k].insn, VECS[k].a, VECS[k].b);
            tag = $sformatf("R%0d", VECS[k].req);
            chk(tag, $sformatf("v%0d wr_en", k), {31'b0, wr_en}, {31'b0, VECS[k].we});
            chk(tag, $sformatf("v%0d load", k), {31'b0, mem_load}, {31'b0, VECS[k].ld});
            chk(tag, $sformatf("v%0d store", k), {31'b0, mem_store}, {31'b0, VECS[k].st});
            if (VECS[k].we)
                chk(tag, $sformatf("v%0d wr_idx", k), {27'b0, wr_idx}, {27'b0, VECS[k].idx});
            if (VECS[k].we || VECS[k].ld || VECS[k].st)
                chk(tag, $sformatf("v%0d result", k), result, VECS[k].res);
            if (VECS[k].ld || VECS[k].st)
                chk(tag, $sformatf("v%0d addr", k), mem_addr, VECS[k].addr);
        end

        // R7: sweep rs value under the same upper-immediate word, result stays fixed
        for (int k = 0; k < 4; k++) begin
            apply(enc_i('h0f, 9, 3, 'h8001), 32'h1 << (k * 8), 32'hFFFFFFFF);
            chk("R7", "upper ignores rs", result, 32'h80010000);
        end
        // R1: hardwired zero ignores a large rt value in a left shift
        apply(enc_r(4, 0, 6, 1, 'h00), 32'h1, 32'hFFFFFFFF);
        chk("R1", "shift of reg0", result, 32'h0);
        // R10: register-register form selects rd, not rt
        apply(enc_r(2, 30, 1, 0, 'h25), 32'h3, 32'h4);
        chk("R10", "rd select", {27'b0, wr_idx}, 32'd1);
        // R8: boundary most negative vs most positive immediate
        apply(enc_i('h0a, 5, 7, 'h7FFF), 32'h80000000, 32'h0);
        chk("R8", "min below max imm", result, 32'h1);
        apply(enc_i('h0a, 5, 7, 'h8000), 32'h7FFFFFFF, 32'h0);
        chk("R8", "max not below min imm", result, 32'h0);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule